// File: doc/BRIEF.md
# Mains-Clocked BCD Calendar Counter

This block keeps time of day and date for a chip that has a 50 Hz or 60 Hz line-frequency tick instead of a crystal. A divider counts the tick pulses and turns them into a one-second advance. The advance drives a BCD chain for seconds, minutes, hours (24-hour), day of week, day of month, month, year and a 2-bit century count. Month lengths and leap years are handled inside the chain, and the year-00 leap rule takes the century count into account.

Software sees the time through a user copy of the eight timekeeping registers. Every cycle the whole copy is loaded at once from the internal counters. While `hold_i` is high the load is skipped, so a multi-byte read sees a consistent snapshot. A write to any timekeeping register loads that field straight into the internal counters and restarts the divider. The block also drives a 1 Hz square wave with a software enable.

The write port is a valid/ready stream. `wr_ready_o` is always high, so the block never applies back-pressure, and a write takes effect on the clock edge where `wr_valid_i` is high. The read port is a plain combinational address/data pair. The tick input must already be synchronous to `clk` and last one cycle per tick.

Top module: `cal_core`

## Requirements
- R1: After reset the registers read: 01h=00h, 02h=00h, 03h=00h, 04h=01h, 05h=81h, 06h=01h, 07h=00h, 0Ah=00h. The square-wave output is low.
- R2: Bit 7 of 05h selects the divide ratio: 1 selects 60 ticks per second, 0 selects 50. The seconds field advances on exactly the last tick of each count and not on the tick before it.
- R3: Bit 6 of 0Ah enables the square wave. When enabled, `sqw_o` is high while the divider has counted fewer than half the ticks of the current second and low for the rest. When disabled, `sqw_o` is low.
- R4: Bit 7 of 01h is the stop bit. While it is 1 the divider and all time fields hold their values. After it is cleared, counting resumes.
- R5: A write to any address 00h–07h loads its fields into the internal time and resets the divider to zero, so a partly counted second starts over. The fields are:
  - 01h: seconds in bits 6:0
  - 02h: minutes in bits 6:0
  - 03h: hours in bits 5:0
  - 04h: day of week in bits 2:0
  - 05h: date in bits 5:0
  - 06h: century in bits 7:6 and month in bits 4:0
  - 07h: year
- R6: While `hold_i` is high the user copy of 00h–07h does not change. The cycle after `hold_i` falls, the user copy shows the current internal time.
- R7: The time fields wrap as follows:
  - seconds go from 59 to 00 and carry into minutes;
  - minutes go from 59 to 00 and carry into hours;
  - hours go from 23 to 00 and carry a day;
  - day of week goes from 7 to 1 on the day carry.
- R8: The date wraps to 01 after the last day of the month and carries into the month. A month has 30 days for months 04, 06, 09 and 11, and 31 days for the other months except February. February has 29 days in a leap year and 28 otherwise. Month 12 wraps to 01 and carries into the year.
- R9: Year 99 wraps to 00 and increments the century bits in binary, with 3 wrapping to 0. Year 00 is a leap year only when the century bits are 00. Any other year is a leap year when it is divisible by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per mains tick, already synchronous |
| hold_i | input | 1 | Freezes the user copy of the time registers |
| wr_valid_i | input | 1 | Register write request |
| wr_ready_o | output | 1 | Write accepted (always high) |
| wr_addr_i | input | 4 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read register address |
| rd_data_o | output | 8 | Read data from the user copy (combinational) |
| sqw_o | output | 1 | 1 Hz square wave |

## Verification
The bench aims at the carry boundaries:
- 23:59:59 on the last day of February in years 24, 23 and 00 under different century values;
- the end of a 30-day month and the end of a 31-day month;
- day of week 7;
- 23:59:59 on Dec 31 of year 99 with the century at 3.

Each of these advances by one second and is compared with a bench model. A design with a wrong leap rule lands on Mar 01 where Feb 29 is due, or the reverse. A design with a wrong century wrap shows a stale or overflowed century field.

Each case first applies one tick short of a full second and checks that nothing moved. An off-by-one divider advances early, or late on the 50 Hz setting.

A second is interrupted by a write to check that the divider restarts. A design that forgets to clear it advances too early. Stop and hold are checked by reading the seconds register after a full second of ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned NREGS = 8;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
    logic [1:0] cb;
  } cal_time_t;

  // Next BCD value without range check.
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // A BCD year is a multiple of four when the units digit suits the tens parity.
  function automatic logic yr_mult4(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  // Last day of the month in BCD.
  function automatic logic [7:0] month_len(input logic [7:0] mon,
                                           input logic [7:0] yr,
                                           input logic [1:0] cb);
    logic leap;
    logic [7:0] r;
    leap = yr_mult4(yr) && !((yr == 8'h00) && (cb != 2'b00));
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int unsigned T50 = 50,
  parameter int unsigned T60 = 60,
  parameter int unsigned CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          clr,
  input  logic          sel60,
  output logic [CW-1:0] cnt,
  output logic          sec_pulse,
  output logic          first_half
);
  logic [CW-1:0] limit;
  logic [CW-1:0] half;
  logic          at_end;

  assign limit  = sel60 ? CW'(T60 - 1) : CW'(T50 - 1);
  assign half   = sel60 ? CW'(T60 / 2) : CW'(T50 / 2);
  assign at_end = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (tick && run) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  assign sec_pulse  = tick && run && !clr && at_end;
  assign first_half = (cnt < half);
endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output cal_time_t  t,
  output logic       st,
  output logic       sel60
);
  logic [7:0] dim;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cb;

  always_comb begin
    dim   = month_len(t.mon, t.yr, t.cb);
    c_min = adv   && (t.sec  == 8'h59);
    c_hr  = c_min && (t.min  == 8'h59);
    c_day = c_hr  && (t.hr   == 8'h23);
    c_mon = c_day && (t.date == dim);
    c_yr  = c_mon && (t.mon  == 8'h12);
    c_cb  = c_yr  && (t.yr   == 8'h99);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t     <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                 date: 8'h01, mon: 8'h01, yr: 8'h00, cb: 2'b00};
      st    <= 1'b0;
      sel60 <= 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        3'd1: begin st <= wr_data[7]; t.sec <= {1'b0, wr_data[6:0]}; end
        3'd2: t.min <= {1'b0, wr_data[6:0]};
        3'd3: t.hr  <= {2'b00, wr_data[5:0]};
        3'd4: t.dow <= {5'b0, wr_data[2:0]};
        3'd5: begin sel60 <= wr_data[7]; t.date <= {2'b00, wr_data[5:0]}; end
        3'd6: begin t.cb <= wr_data[7:6]; t.mon <= {3'b000, wr_data[4:0]}; end
        3'd7: t.yr <= wr_data;
        default: ;
      endcase
    end else begin
      if (adv)   t.sec  <= (t.sec == 8'h59) ? 8'h00 : bcd_next(t.sec);
      if (c_min) t.min  <= (t.min == 8'h59) ? 8'h00 : bcd_next(t.min);
      if (c_hr)  t.hr   <= (t.hr  == 8'h23) ? 8'h00 : bcd_next(t.hr);
      if (c_day) begin
        t.dow  <= (t.dow == 8'h07) ? 8'h01 : t.dow + 8'h01;
        t.date <= (t.date == dim)  ? 8'h01 : bcd_next(t.date);
      end
      if (c_mon) t.mon  <= (t.mon == 8'h12) ? 8'h01 : bcd_next(t.mon);
      if (c_yr)  t.yr   <= (t.yr  == 8'h99) ? 8'h00 : bcd_next(t.yr);
      if (c_cb)  t.cb   <= t.cb + 2'b01;
    end
  end
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow #(
  parameter int unsigned          NB      = 8,
  parameter int unsigned          DW      = 8,
  parameter logic [NB*DW-1:0]     RST_IMG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [NB*DW-1:0] live,
  output logic [NB*DW-1:0] user
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     user[i*DW +: DW] <= RST_IMG[i*DW +: DW];
      else if (!hold) user[i*DW +: DW] <= live[i*DW +: DW];
    end
  end
endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
#(
  parameter int unsigned T50      = 50,
  parameter int unsigned T60      = 60,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 8,
  parameter logic [3:0]  SQW_ADDR = 4'hA,
  parameter int unsigned SQW_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          sqw_o
);
  localparam int unsigned DIV_MAX = (T60 > T50) ? T60 : T50;
  localparam int unsigned CW      = $clog2(DIV_MAX + 1);
  localparam int unsigned IW      = $clog2(NREGS);
  localparam int unsigned IMG_W   = NREGS * DW;
  localparam logic [IMG_W-1:0] RST_IMG = IMG_W'(64'h00_01_81_01_00_00_00_00);

  logic             wr_fire, wr_time, sqwe_q;
  logic [CW-1:0]    div_cnt;
  logic             sec_pulse, first_half;
  cal_time_t        t;
  logic             st, sel60;
  logic [IMG_W-1:0] live_img, user_img;

  assign wr_ready_o = 1'b1;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign wr_time    = wr_fire && (wr_addr_i < AW'(NREGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sqwe_q <= 1'b0;
    else if (wr_fire && wr_addr_i == SQW_ADDR) sqwe_q <= wr_data_i[SQW_BIT];
  end

  cal_divider #(.T50(T50), .T60(T60), .CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(!st), .clr(wr_time),
    .sel60(sel60), .cnt(div_cnt), .sec_pulse(sec_pulse), .first_half(first_half)
  );

  cal_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(sec_pulse), .wr_en(wr_time),
    .wr_sel(wr_addr_i[2:0]), .wr_data(wr_data_i), .t(t), .st(st), .sel60(sel60)
  );

  assign live_img = {t.yr,
                     t.cb, 1'b0, t.mon[4:0],
                     sel60, 1'b0, t.date[5:0],
                     5'b0, t.dow[2:0],
                     2'b0, t.hr[5:0],
                     1'b0, t.min[6:0],
                     st, t.sec[6:0],
                     8'h00};

  cal_shadow #(.NB(NREGS), .DW(DW), .RST_IMG(RST_IMG)) u_shadow (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .live(live_img), .user(user_img)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < AW'(NREGS))
      rd_data_o = user_img[int'(rd_addr_i[IW-1:0]) * DW +: DW];
    else if (rd_addr_i == SQW_ADDR)
      rd_data_o[SQW_BIT] = sqwe_q;
  end

  assign sqw_o = sqwe_q && first_half;
endmodule

// File: rtl/cal_core_chk.sv
module cal_core_chk #(
  parameter int unsigned T50   = 50,
  parameter int unsigned T60   = 60,
  parameter int unsigned CW    = 6,
  parameter int unsigned AW    = 4,
  parameter int unsigned IMG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_i,
  input logic             wr_fire,
  input logic [AW-1:0]    wr_addr_i,
  input logic             sel60,
  input logic             st,
  input logic             sqwe_q,
  input logic [CW-1:0]    div_cnt,
  input logic             sqw_o,
  input logic [IMG_W-1:0] user_img
);
  // R2
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(div_cnt) < (sel60 ? int'(T60) : int'(T50)));

  // R4
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !wr_fire) |=> $stable(div_cnt));

  // R5
  wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr_i < AW'(8)) |=> (div_cnt == '0));

  // R6
  hold_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(user_img));

  // R3
  sqw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_o) |-> ((div_cnt == '0) || $rose(sqwe_q)));
endmodule

bind cal_core cal_core_chk #(
  .T50(T50), .T60(T60), .CW(CW), .AW(AW), .IMG_W(IMG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .wr_fire(wr_fire),
  .wr_addr_i(wr_addr_i), .sel60(sel60), .st(st), .sqwe_q(sqwe_q),
  .div_cnt(div_cnt), .sqw_o(sqw_o), .user_img(user_img)
);

// File: tb/tb_cal_core.sv
module tb_cal_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, hold_i = 1'b0, wr_valid_i = 1'b0;
  logic       wr_ready_o, sqw_o;
  logic [3:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int ms, mm, mh, mw, md, mmo, my, mc;

  always #10 clk = ~clk;

  cal_core dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bcd(input int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic int dim(input int mo, input int y, input int c);
    bit leap;
    leap = (y % 4 == 0) && !(y == 0 && c != 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv_model();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mw = (mw == 7) ? 1 : mw + 1;
      md++;
      if (md > dim(mmo, my, mc)) begin md = 1; mmo++; end
      if (mmo == 13) begin mmo = 1; my++; end
      if (my == 100) begin my = 0; mc = (mc + 1) % 4; end
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr_i = 4'(a);
    #1 d = int'(rd_data_o);
  endtask

  task automatic run_case(input int s, m, h, w, d, mo, y, c, sel);
    int v;
    ms = s; mm = m; mh = h; mw = w; md = d; mmo = mo; my = y; mc = c;
    wr(1, bcd(s)); wr(2, bcd(m)); wr(3, bcd(h)); wr(4, w);
    wr(5, (sel << 7) | bcd(d)); wr(6, (c << 6) | bcd(mo)); wr(7, bcd(y));
    ticks(sel ? 59 : 49);
    rd(1, v); chk("R2 no advance before last tick", v, bcd(s));
    ticks(1);
    adv_model();
    rd(1, v); chk("R7 seconds", v, bcd(ms));
    rd(2, v); chk("R7 minutes", v, bcd(mm));
    rd(3, v); chk("R7 hours", v, bcd(mh));
    rd(4, v); chk("R7 day of week", v, mw);
    rd(5, v); chk("R8 date", v, (sel << 7) | bcd(md));
    rd(6, v); chk("R8 R9 century/month", v, (mc << 6) | bcd(mmo));
    rd(7, v); chk("R9 year", v, bcd(my));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(1, v); chk("R1 reg01", v, 8'h00);
    rd(2, v); chk("R1 reg02", v, 8'h00);
    rd(3, v); chk("R1 reg03", v, 8'h00);
    rd(4, v); chk("R1 reg04", v, 8'h01);
    rd(5, v); chk("R1 reg05", v, 8'h81);
    rd(6, v); chk("R1 reg06", v, 8'h01);
    rd(7, v); chk("R1 reg07", v, 8'h00);
    rd(10, v); chk("R1 reg0A", v, 8'h00);
    chk("R1 sqw low", int'(sqw_o), 0);
    wr_data_i = 8'h00;
    chk("R5 write ready", int'(wr_ready_o), 1);

    // R3 square wave at 60 ticks per second
    wr(10, 8'h40);
    rd(10, v); chk("R3 enable readback", v, 8'h40);
    chk("R3 high at start", int'(sqw_o), 1);
    ticks(29); chk("R3 high at 29", int'(sqw_o), 1);
    ticks(1);  chk("R3 low at 30", int'(sqw_o), 0);
    ticks(29); chk("R3 low at 59", int'(sqw_o), 0);
    rd(1, v);  chk("R2 seconds before wrap", v, 8'h00);
    ticks(1);  chk("R3 high after wrap", int'(sqw_o), 1);
    rd(1, v);  chk("R2 seconds after 60 ticks", v, 8'h01);
    wr(10, 8'h00);
    chk("R3 disabled low", int'(sqw_o), 0);
    ticks(5);  chk("R3 stays low", int'(sqw_o), 0);

    // R5 write restarts the divider
    ticks(35);
    wr(2, 8'h15);
    ticks(59);
    rd(1, v); chk("R5 restart no early advance", v, 8'h01);
    rd(2, v); chk("R5 minutes loaded", v, 8'h15);
    ticks(1);
    rd(1, v); chk("R5 advance after full second", v, 8'h02);

    // R4 stop bit
    wr(1, 8'hB0);
    ticks(120);
    rd(1, v); chk("R4 stopped", v, 8'hB0);
    wr(1, 8'h30);
    ticks(60);
    rd(1, v); chk("R4 resumed", v, 8'h31);

    // R6 hold
    hold_i = 1'b1;
    ticks(60);
    rd(1, v); chk("R6 frozen", v, 8'h31);
    hold_i = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, v); chk("R6 released", v, 8'h32);

    // directed calendar corners
    run_case(59, 59, 23, 3, 28, 2, 24, 0, 1); // R8 leap Feb
    run_case(59, 59, 23, 4, 29, 2, 24, 0, 1);
    run_case(59, 59, 23, 5, 28, 2, 23, 0, 1);
    run_case(59, 59, 23, 6, 28, 2, 0, 1, 1);  // R9 year 00 not leap
    run_case(59, 59, 23, 7, 28, 2, 0, 0, 1);  // R9 year 00 leap, R7 dow wrap
    run_case(59, 59, 23, 1, 30, 4, 10, 2, 0);
    run_case(59, 59, 23, 2, 31, 1, 10, 2, 0);
    run_case(59, 59, 23, 7, 31, 12, 99, 3, 0); // R9 century wrap
    run_case(59, 34, 12, 2, 15, 7, 45, 1, 1);

    // constrained random
    for (int k = 0; k < 30; k++) begin
      int s, m, h, w, d, mo, y, c, sel, dm;
      s   = ($urandom % 3 == 0) ? 59 : $urandom % 60;
      m   = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      h   = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      w   = 1 + $urandom % 7;
      mo  = ($urandom % 4 == 0) ? 2 : 1 + $urandom % 12;
      y   = ($urandom % 4 == 0) ? 99 : (($urandom % 4 == 0) ? 0 : $urandom % 100);
      c   = $urandom % 4;
      dm  = dim(mo, y, c);
      d   = ($urandom % 2 == 0) ? dm : 1 + $urandom % dm;
      sel = $urandom % 2;
      run_case(s, m, h, w, d, mo, y, c, sel);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule